// File: doc/BRIEF.md
# Nibble-Prefix Instruction Decoder

This block is the fetch and decode stage of a small stack machine whose instructions are one byte each. The high four bits of a byte pick a primary function and the low four bits are an immediate nibble. The nibble is merged into an operand register. Two prefix functions build wide or negative constants by shifting that register left one nibble per byte. An operate function takes the merged operand as a secondary opcode for zero-operand operations.

The decoder holds a three-entry evaluation stack (top A, then B, then C). Loading a constant pushes it. Loads and stores of locals address memory at a workspace pointer plus the operand. Jumps and operate codes are handed to the rest of the processor as one-cycle strobes. Instruction bytes arrive with a valid/ready handshake. A local load holds ready low for one cycle while the synchronous memory returns its data.

Top module: `pfx_decoder`

## Requirements
- R1: After reset, A, B, C and the operand register are zero, `in_ready` is 1, and none of `mem_rd_en`, `mem_wr_en`, `jump_en` or `opr_en` is high.
- R2: A byte is accepted in a cycle with `in_valid` and `in_ready` both high. The function is bits 7:4 and the nibble is bits 3:0. The effective operand is the operand register ORed with the nibble.
- R3: Function 0x2 (prefix) sets the operand register to the effective operand shifted left by 4. Prefix 1 followed by load-constant 2 pushes 0x12.
- R4: Function 0x6 (negative prefix) sets the operand register to the bitwise complement of the effective operand, shifted left by 4. Negative prefix 0 followed by load-constant 0xF pushes 0xFFFFFFFF.
- R5: A chain of seven prefixes followed by load-constant pushes any 32-bit constant, with its nibbles given most significant first.
- R6: Every accepted function other than the two prefixes clears the operand register. A following load-constant n therefore pushes exactly n.
- R7: Function 0x4 (load constant) pushes the effective operand. The old A moves to B and the old B moves to C.
- R8: Function 0x7 (load local) raises `mem_rd_en` in the accepting cycle with `mem_addr` = `wptr` + operand. In the next cycle `in_ready` is 0. At the end of that cycle `mem_rdata` is pushed and `in_ready` returns to 1.
- R9: Function 0xD (store local) raises `mem_wr_en` with `mem_addr` = `wptr` + operand and `mem_wdata` = A. It then pops: B moves to A and C moves to B.
- R10: Function 0xF (operate) raises `opr_en` with `opr_code` = operand. Code 0x05 replaces A with B+A and code 0x0C replaces A with B−A; both move C to B. Any other code leaves the stack unchanged.
- R11: Function 0x0 (jump) raises `jump_en` with `jump_ofs` = operand.
- R12: In a cycle with no accepted byte and no pending load, no strobe is raised and the stack holds. Primary codes that are not listed leave the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can accept a byte |
| wptr | input | W | Workspace pointer |
| mem_rd_en | output | 1 | Local load request |
| mem_wr_en | output | 1 | Local store request |
| mem_addr | output | W | Local address (wptr + operand) |
| mem_wdata | output | W | Store data (A) |
| mem_rdata | input | W | Load data, valid the cycle after `mem_rd_en` |
| jump_en | output | 1 | Jump strobe |
| jump_ofs | output | W | Jump offset |
| opr_en | output | 1 | Operate strobe |
| opr_code | output | W | Secondary opcode |
| stk_a | output | W | Stack top |
| stk_b | output | W | Stack second |
| stk_c | output | W | Stack third |

## Verification
Two events can touch the operand path in the same cycle. One is a prefix shift. The other is the clear that any other accepted function causes. The sweeps therefore put every prefix nibble directly ahead of every load-constant nibble, and then follow each pair with a bare load-constant that must push only its own nibble. A second collision can occur between a pending load push and a new byte. The bench judges it by offering a byte right after a local load and checking that ready is low, that the loaded word lands on top exactly once, and that the offered byte is taken only in the following cycle.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    typedef enum logic [3:0] {
        FN_JUMP = 4'h0,
        FN_PFX  = 4'h2,
        FN_LDC  = 4'h4,
        FN_NPFX = 4'h6,
        FN_LDL  = 4'h7,
        FN_STL  = 4'hD,
        FN_OPR  = 4'hF
    } fn_e;

    typedef enum logic [2:0] {
        STK_HOLD,
        STK_PUSH,
        STK_POP,
        STK_ADD,
        STK_SUB
    } stk_cmd_e;

    localparam logic [7:0] SEC_ADD = 8'h05;
    localparam logic [7:0] SEC_SUB = 8'h0C;
endpackage

// File: rtl/pfx_operand.sv
module pfx_operand #(
    parameter int W = 32,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [NIB_W-1:0] fn,
    input  logic [NIB_W-1:0] nib,
    output logic [W-1:0]     eff
);
    import pfx_pkg::*;

    typedef struct packed {
        logic [W-1:0] oper;
    } opr_state_t;

    opr_state_t st_d, st_q;

    assign eff = st_q.oper | W'(nib);

    always_comb begin
        st_d = st_q;
        if (fire) begin
            if (fn == FN_PFX)
                st_d.oper = eff << NIB_W;
            else if (fn == FN_NPFX)
                st_d.oper = (~eff) << NIB_W;
            else
                st_d.oper = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pfx_stack.sv
module pfx_stack #(
    parameter int W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  pfx_pkg::stk_cmd_e        cmd,
    input  logic [W-1:0]             push_val,
    output logic [W-1:0]             a,
    output logic [W-1:0]             b,
    output logic [W-1:0]             c
);
    import pfx_pkg::*;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] c;
    } stk_state_t;

    stk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            STK_PUSH: begin
                st_d.a = push_val;
                st_d.b = st_q.a;
                st_d.c = st_q.b;
            end
            STK_POP: begin
                st_d.a = st_q.b;
                st_d.b = st_q.c;
            end
            STK_ADD: begin
                st_d.a = st_q.b + st_q.a;
                st_d.b = st_q.c;
            end
            STK_SUB: begin
                st_d.a = st_q.b - st_q.a;
                st_d.b = st_q.c;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a = st_q.a;
    assign b = st_q.b;
    assign c = st_q.c;
endmodule

// File: rtl/pfx_decoder.sv
module pfx_decoder #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [7:0]   in_byte,
    output logic         in_ready,
    input  logic [W-1:0] wptr,
    output logic         mem_rd_en,
    output logic         mem_wr_en,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         jump_en,
    output logic [W-1:0] jump_ofs,
    output logic         opr_en,
    output logic [W-1:0] opr_code,
    output logic [W-1:0] stk_a,
    output logic [W-1:0] stk_b,
    output logic [W-1:0] stk_c
);
    import pfx_pkg::*;

    localparam int NIB_W = 4;

    typedef struct packed {
        logic wait_ld;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic              fire;
    logic [NIB_W-1:0]  fn;
    logic [NIB_W-1:0]  nib;
    logic [W-1:0]      eff;
    stk_cmd_e          cmd;
    logic [W-1:0]      push_val;

    assign fn       = in_byte[7:4];
    assign nib      = in_byte[3:0];
    assign in_ready = !st_q.wait_ld;
    assign fire     = in_valid && in_ready;

    pfx_operand #(.W(W), .NIB_W(NIB_W)) u_operand (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .fn    (fn),
        .nib   (nib),
        .eff   (eff)
    );

    pfx_stack #(.W(W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .push_val (push_val),
        .a        (stk_a),
        .b        (stk_b),
        .c        (stk_c)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wait_ld = 1'b0;
        cmd       = STK_HOLD;
        push_val  = eff;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = wptr + eff;
        mem_wdata = stk_a;
        jump_en   = 1'b0;
        jump_ofs  = eff;
        opr_en    = 1'b0;
        opr_code  = eff;
        if (st_q.wait_ld) begin
            cmd      = STK_PUSH;
            push_val = mem_rdata;
        end else if (fire) begin
            unique case (fn)
                FN_LDC:  cmd = STK_PUSH;
                FN_LDL: begin
                    mem_rd_en    = 1'b1;
                    st_d.wait_ld = 1'b1;
                end
                FN_STL: begin
                    mem_wr_en = 1'b1;
                    cmd       = STK_POP;
                end
                FN_JUMP: jump_en = 1'b1;
                FN_OPR: begin
                    opr_en = 1'b1;
                    if (eff == W'(SEC_ADD))      cmd = STK_ADD;
                    else if (eff == W'(SEC_SUB)) cmd = STK_SUB;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pfx_decoder_chk.sv
module pfx_decoder_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         mem_rd_en,
    input logic         mem_wr_en,
    input logic         jump_en,
    input logic         opr_en,
    input logic [W-1:0] stk_a,
    input logic [W-1:0] stk_b
);
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, mem_wr_en, jump_en, opr_en}));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |-> !(mem_rd_en || mem_wr_en || jump_en || opr_en));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> ($stable(stk_a) && $stable(stk_b)));

    // R8
    load_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !in_ready);

    // R8
    stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    // R9
    store_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (stk_a == $past(stk_b)));
endmodule

bind pfx_decoder pfx_decoder_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .jump_en   (jump_en),
    .opr_en    (opr_en),
    .stk_a     (stk_a),
    .stk_b     (stk_b)
);

// File: tb/tb_pfx_decoder.sv
module tb_pfx_decoder;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_byte = '0;
    logic         in_ready;
    logic [W-1:0] wptr = 32'd4;
    logic         mem_rd_en, mem_wr_en, jump_en, opr_en;
    logic [W-1:0] mem_addr, mem_wdata, jump_ofs, opr_code;
    logic [W-1:0] mem_rdata = '0;
    logic [W-1:0] stk_a, stk_b, stk_c;
    logic [W-1:0] mem [16];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic         s_rd, s_wr, s_jmp, s_opr;
    logic [W-1:0] s_addr, s_wdata, s_jofs, s_ocode;

    always #10 clk = ~clk;

    pfx_decoder #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .wptr(wptr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .jump_en(jump_en), .jump_ofs(jump_ofs),
        .opr_en(opr_en), .opr_code(opr_code), .stk_a(stk_a), .stk_b(stk_b),
        .stk_c(stk_c)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[3:0]];
        if (mem_wr_en) mem[mem_addr[3:0]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one byte at a falling edge, capture strobes before the rising edge
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        #5;
        s_rd = mem_rd_en; s_wr = mem_wr_en; s_jmp = jump_en; s_opr = opr_en;
        s_addr = mem_addr; s_wdata = mem_wdata; s_jofs = jump_ofs; s_ocode = opr_code;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    task automatic push_const(input logic [W-1:0] v);
        for (int i = 7; i >= 1; i--) send({4'h2, v[i*4 +: 4]});
        send({4'h4, v[3:0]});
    endtask

    initial begin
        logic [W-1:0] exp, a0, b0, c0;
        for (int i = 0; i < 16; i++) mem[i] = 32'hA500_0000 + i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 a", stk_a, 0); check("R1 b", stk_b, 0); check("R1 c", stk_c, 0);
        check("R1 ready", {31'b0, in_ready}, 1);
        check("R1 strobes", {28'b0, mem_rd_en, mem_wr_en, jump_en, opr_en}, 0);
        rst_n = 1'b1;

        // R7 R6 single-byte constants, all nibbles, with stack shift
        for (int n = 0; n < 16; n++) begin
            a0 = stk_a; b0 = stk_b;
            send({4'h4, n[3:0]}); settle();
            check("R7 ldc", stk_a, W'(n));
            check("R7 shift b", stk_b, a0);
            check("R7 shift c", stk_c, b0);
        end

        // R3 prefix sweep, then R6 clear
        for (int p = 0; p < 16; p++) begin
            for (int n = 0; n < 16; n++) begin
                send({4'h2, p[3:0]}); send({4'h4, n[3:0]}); settle();
                check("R3 pfix", stk_a, W'((p << 4) | n));
                send({4'h4, n[3:0]}); settle();
                check("R6 clear", stk_a, W'(n));
            end
        end
        send(8'h21); send(8'h42); settle();
        check("R3 0x12", stk_a, 32'h12);

        // R4 negative prefix sweep
        for (int p = 0; p < 16; p++) begin
            for (int n = 0; n < 16; n++) begin
                send({4'h6, p[3:0]}); send({4'h4, n[3:0]}); settle();
                exp = ((~W'(p)) << 4) | W'(n);
                check("R4 nfix", stk_a, exp);
            end
        end
        send(8'h60); send(8'h4F); settle();
        check("R4 minus one", stk_a, 32'hFFFF_FFFF);
        send(8'h60); send(8'h20); send(8'h40); settle();
        check("R4 nfix then pfix", stk_a, 32'hFFFF_FF00);

        // R5 long chains
        push_const(32'hDEAD_BEEF); settle(); check("R5 chain", stk_a, 32'hDEAD_BEEF);
        push_const(32'h8000_0001); settle(); check("R5 chain", stk_a, 32'h8000_0001);
        push_const(32'h1234_5678); settle(); check("R5 chain", stk_a, 32'h1234_5678);

        // R11 jump with prefixed offset, R6 clear afterwards
        send(8'h23); send(8'h05);
        check("R11 jump_en", {31'b0, s_jmp}, 1);
        check("R11 jump_ofs", s_jofs, 32'h35);
        send(8'h47); settle(); check("R6 after jump", stk_a, 32'h7);

        // R10 add / subtract
        push_const(32'd100); push_const(32'd30);
        send(8'hF5); settle();
        check("R10 opr_en", {31'b0, s_opr}, 1);
        check("R10 opr_code", s_ocode, 32'h05);
        check("R10 add", stk_a, 32'd130);
        push_const(32'd200); push_const(32'd50);
        send(8'hFC); settle();
        check("R10 sub", stk_a, 32'd150);
        a0 = stk_a; b0 = stk_b;
        send(8'h21); send(8'hF0); settle();
        check("R10 ext code", s_ocode, 32'h10);
        check("R12 other opr a", stk_a, a0);
        check("R12 other opr b", stk_b, b0);

        // R9 store local
        push_const(32'h0000_0077); push_const(32'h0000_1234);
        a0 = stk_a; b0 = stk_b; c0 = stk_c;
        send(8'hD3); settle();
        check("R9 wr_en", {31'b0, s_wr}, 1);
        check("R9 addr", s_addr, 32'd7);
        check("R9 wdata", s_wdata, a0);
        check("R9 pop a", stk_a, b0);
        check("R9 pop b", stk_b, c0);

        // R8 load local with back-to-back byte
        send(8'h21); send(8'h72);
        check("R8 rd_en", {31'b0, s_rd}, 1);
        check("R8 addr", s_addr, 32'd4 + 32'h12);
        @(negedge clk);
        check("R8 stall", {31'b0, in_ready}, 0);
        in_valid = 1'b1; in_byte = 8'h49;
        @(posedge clk); #1;
        check("R8 pushed", stk_a, mem[6]);
        @(posedge clk); #1 in_valid = 1'b0;
        check("R8 next byte", stk_a, 32'h9);
        check("R8 order", stk_b, mem[6]);
        send(8'h73); settle();
        check("R8 stored word", stk_a, 32'h1234);

        // R12 idle and unused primaries
        a0 = stk_a; b0 = stk_b;
        repeat (4) @(negedge clk);
        check("R12 idle a", stk_a, a0);
        for (int f = 0; f < 16; f++) begin
            if (f inside {0, 2, 4, 6, 7, 13, 15}) continue;
            send({f[3:0], 4'h3}); settle();
            check("R12 unused", stk_a, a0);
            check("R12 unused b", stk_b, b0);
        end
        send(8'h41); settle(); check("R6 after unused", stk_a, 32'h1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule